// File: doc/BRIEF.md
# Central Bus Arbiter with Stalled-Master Exclusion

This block decides which master may own a shared PCI-style bus. It serves a parameterised number of external masters, each with an active-low request and grant pin, plus one internal host master with active-high request and grant. Only one grant is driven at a time. The arbiter watches the bus framing and initiator-ready strobes to tell when the bus is idle. Ownership changes only while the bus is idle, and an empty clock always separates two owners.

A master that holds a grant while the bus sits idle and never starts a cycle is treated as stalled. Once the idle window has run out, its grant is withdrawn and its request is ignored until it lets the request go for at least one clock. A static control bit turns this exclusion off. When nobody eligible is requesting, a two-bit parking selector decides who holds the idle bus.

Top module: `pci_central_arbiter`

## Requirements
- R1: All inputs are sampled on the rising clock edge and the grants change only on the edge after the one that sampled them. At most one grant is active in any cycle. A grant changes only after an edge that sampled `frame_n` and `irdy_n` both high (bus idle). Between grants to two different masters there is at least one cycle with no grant.
- R2: Eligible masters are those requesting and not excluded. Among them, the winner is the first one found in rising index order, wrapping around, starting just after the master granted last. External master i has index i and the host has index N_EXT.
- R3: With `lock_dis` = 0, a granted, requesting, eligible master that has not started a cycle since its grant loses the grant after WINDOW (default 16) consecutive idle sampled edges. Its grant is then seen for exactly WINDOW cycles, and the master becomes excluded.
- R4: An excluded master is never granted while it keeps requesting. The exclusion clears at an edge that samples its request deasserted. After that, the master is arbitrated normally.
- R5: With `lock_dis` = 1, no master is ever excluded. A granted master keeps its grant until it starts a cycle or drops its request.
- R6: An owner that has run a cycle is re-arbitrated at the next idle edge. If it is the only eligible requester, it keeps the grant with no gap.
- R7: With no eligible requester, `park_mode` = 2'b00 parks the bus on the master granted last.
- R8: `park_mode` = 2'b01 parks the bus on external master 0.
- R9: `park_mode` = 2'b10 and the reserved code 2'b11 both park the bus on the host master.
- R10: During and right after reset, no grant is driven and the last-granted master is the host. If the parking target is excluded, no grant is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | N_EXT | External master requests, active low |
| host_req | input | 1 | Internal host request, active high |
| frame_n | input | 1 | Bus framing strobe, active low |
| irdy_n | input | 1 | Initiator-ready strobe, active low |
| lock_dis | input | 1 | 1 disables stalled-master exclusion |
| park_mode | input | 2 | Parking policy: 00 last, 01 master 0, 10/11 host |
| gnt_n | output | N_EXT | External master grants, active low |
| host_gnt | output | 1 | Internal host grant, active high |

## Verification
Two functions can land on the same edge: the expiry of a stalled master's idle window and the arrival of another master's request. The bench waits for the stalled master's grant to appear. It then counts clocks and times the second request so that it is sampled on the very edge where the window runs out. The cycle model and a directed check both expect the same outcome: the grant is withdrawn, one empty cycle follows, and the newcomer is granted, while the stalled master stays excluded and keeps requesting.

// File: rtl/parb_pkg.sv
package parb_pkg;

   // parking policy codes; the reserved code behaves like the host code
   typedef enum logic [1:0] {
      PARK_LAST     = 2'b00,
      PARK_ZERO     = 2'b01,
      PARK_HOST     = 2'b10,
      PARK_HOST_ALT = 2'b11
   } park_mode_e;

endpackage

// File: rtl/parb_rr_pick.sv
module parb_rr_pick #(
   parameter int M  = 5,
   parameter int IW = 3
) (
   input  logic [M-1:0]  elig,
   input  logic [IW-1:0] last,
   output logic          found,
   output logic [IW-1:0] win
);

   logic [IW-1:0] cand [M];

   // candidate k is the (k+1)-th index after the last winner, wrapped
   always_comb begin
      for (int k = 0; k < M; k++) begin
         if (int'(last) + k + 1 >= M)
            cand[k] = IW'(int'(last) + k + 1 - M);
         else
            cand[k] = IW'(int'(last) + k + 1);
      end
   end

   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int k = 0; k < M; k++) begin
         if (!found && elig[cand[k]]) begin
            found = 1'b1;
            win   = cand[k];
         end
      end
   end

endmodule

// File: rtl/parb_park_sel.sv
module parb_park_sel
   import parb_pkg::*;
#(
   parameter int M  = 5,
   parameter int IW = 3
) (
   input  logic [1:0]    mode,
   input  logic [IW-1:0] last,
   input  logic [M-1:0]  locked,
   output logic [IW-1:0] target,
   output logic          ok
);

   localparam logic [IW-1:0] HOST_ID = IW'(M - 1);

   always_comb begin
      unique case (park_mode_e'(mode))
         PARK_LAST: target = last;
         PARK_ZERO: target = '0;
         default:   target = HOST_ID;
      endcase
      ok = !locked[target];
   end

endmodule

// File: rtl/parb_lockout.sv
module parb_lockout #(
   parameter int M      = 5,
   parameter int IW     = 3,
   parameter int WINDOW = 16,
   parameter int CW     = $clog2(WINDOW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock_en,
   input  logic          owner_vld,
   input  logic [IW-1:0] owner,
   input  logic          idle,
   input  logic          used,
   input  logic [M-1:0]  req,
   output logic [M-1:0]  locked,
   output logic          expire
);

   localparam logic [CW-1:0] LIMIT = CW'(WINDOW - 1);

   logic [CW-1:0] cnt;
   logic          owner_elig;
   logic          counting;

   assign owner_elig = req[owner] & ~locked[owner];
   assign counting   = owner_vld & idle & ~used & owner_elig;
   assign expire     = lock_en & counting & (cnt == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!counting || expire) begin
         cnt <= '0;
      end else if (cnt != LIMIT) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= '0;
      end else begin
         for (int i = 0; i < M; i++) begin
            if (expire && owner == IW'(i))
               locked[i] <= 1'b1;
            else if (!req[i])
               locked[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pci_central_arbiter.sv
module pci_central_arbiter
   import parb_pkg::*;
#(
   parameter int N_EXT  = 4,
   parameter int WINDOW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT-1:0] req_n,
   input  logic             host_req,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic             lock_dis,
   input  logic [1:0]       park_mode,
   output logic [N_EXT-1:0] gnt_n,
   output logic             host_gnt
);

   localparam int M    = N_EXT + 1;
   localparam int IW   = (M > 1) ? $clog2(M) : 1;
   localparam int HOST = N_EXT;

   if (N_EXT < 1) begin : g_bad_count
      $error("pci_central_arbiter: N_EXT must be at least 1");
   end
   if (WINDOW < 2) begin : g_bad_window
      $error("pci_central_arbiter: WINDOW must be at least 2");
   end

   logic [M-1:0]  req;
   logic [M-1:0]  locked_q;
   logic [M-1:0]  elig;
   logic          idle;
   logic          expire;

   logic          gnt_vld, nxt_vld;
   logic [IW-1:0] owner, nxt_owner;
   logic [IW-1:0] last, nxt_last;
   logic          used, nxt_used;

   logic          rr_found;
   logic [IW-1:0] rr_win;
   logic [IW-1:0] park_tgt;
   logic          park_ok;
   logic          keep_owner;

   for (genvar i = 0; i < N_EXT; i++) begin : g_req
      assign req[i] = ~req_n[i];
   end
   assign req[HOST] = host_req;

   assign idle = frame_n & irdy_n;
   assign elig = req & ~locked_q;

   parb_rr_pick #(.M(M), .IW(IW)) u_rr (
      .elig  (elig),
      .last  (last),
      .found (rr_found),
      .win   (rr_win)
   );

   parb_park_sel #(.M(M), .IW(IW)) u_park (
      .mode   (park_mode),
      .last   (last),
      .locked (locked_q),
      .target (park_tgt),
      .ok     (park_ok)
   );

   parb_lockout #(.M(M), .IW(IW), .WINDOW(WINDOW)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_en   (~lock_dis),
      .owner_vld (gnt_vld),
      .owner     (owner),
      .idle      (idle),
      .used      (used),
      .req       (req),
      .locked    (locked_q),
      .expire    (expire)
   );

   // current owner survives re-arbitration when it is still the choice
   assign keep_owner = rr_found ? (rr_win == owner) : (park_ok && park_tgt == owner);

   always_comb begin
      nxt_vld   = gnt_vld;
      nxt_owner = owner;
      nxt_last  = last;
      nxt_used  = used;
      if (!gnt_vld) begin
         nxt_used = 1'b0;
         if (idle) begin
            if (rr_found) begin
               nxt_vld   = 1'b1;
               nxt_owner = rr_win;
               nxt_last  = rr_win;
            end else if (park_ok) begin
               nxt_vld   = 1'b1;
               nxt_owner = park_tgt;
               nxt_last  = park_tgt;
            end
         end
      end else if (!idle) begin
         nxt_used = 1'b1;
      end else if (expire) begin
         nxt_vld = 1'b0;
      end else if (used || !elig[owner]) begin
         if (keep_owner)
            nxt_used = 1'b0;
         else
            nxt_vld = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_vld <= 1'b0;
         owner   <= '0;
         last    <= IW'(HOST);
         used    <= 1'b0;
      end else begin
         gnt_vld <= nxt_vld;
         owner   <= nxt_owner;
         last    <= nxt_last;
         used    <= nxt_used;
      end
   end

   for (genvar i = 0; i < N_EXT; i++) begin : g_gnt
      assign gnt_n[i] = ~(gnt_vld && owner == IW'(i));
   end
   assign host_gnt = gnt_vld && owner == IW'(HOST);

endmodule

// File: rtl/parb_checker.sv
module parb_checker #(
   parameter int N_EXT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_EXT-1:0] req_n,
   input logic             host_req,
   input logic             frame_n,
   input logic             irdy_n,
   input logic             lock_dis,
   input logic [N_EXT-1:0] gnt_n,
   input logic             host_gnt,
   input logic [N_EXT:0]   locked
);

   logic [N_EXT:0] g;
   logic [N_EXT:0] r;

   assign g = {host_gnt, ~gnt_n};
   assign r = {host_req, ~req_n};

   // R1: never two grants
   p_single_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(g));

   // R1: no direct hand-over between two masters
   p_grant_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|g && |$past(g)) |-> (g == $past(g)));

   // R1: grants move only after an idle sample
   p_move_on_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (g != $past(g)) |-> $past(frame_n && irdy_n));

   // R4: an excluded master is never newly granted
   p_no_grant_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((g & ~$past(g) & $past(locked)) == '0));

   // R4: exclusion persists while the request stays asserted
   p_lock_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(locked) & $past(r) & ~locked) == '0));

   // R3: exclusion only hits a requesting master
   p_lock_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((locked & ~$past(locked) & ~$past(r)) == '0));

   // R5: no exclusion while the feature is disabled
   p_no_lock_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(locked & ~$past(locked))) |-> !$past(lock_dis));

endmodule

bind pci_central_arbiter parb_checker #(.N_EXT(N_EXT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_n    (req_n),
   .host_req (host_req),
   .frame_n  (frame_n),
   .irdy_n   (irdy_n),
   .lock_dis (lock_dis),
   .gnt_n    (gnt_n),
   .host_gnt (host_gnt),
   .locked   (locked_q)
);

// File: tb/sim_pci_central_arbiter.sv
`timescale 1ns/1ps
module sim_pci_central_arbiter;

   localparam int N_EXT = 4;
   localparam int WIN   = 16;
   localparam int M     = N_EXT + 1;
   localparam int HOST  = N_EXT;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_EXT-1:0] req_n = '1;
   logic             host_req = 1'b0;
   logic             frame_n = 1'b1;
   logic             irdy_n = 1'b1;
   logic             lock_dis = 1'b0;
   logic [1:0]       park_mode = 2'b10;
   logic [N_EXT-1:0] gnt_n;
   logic             host_gnt;
   logic [M-1:0]     g_obs;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string cur_tag = "R10";

   // reference model state
   int m_owner = -1;
   int m_last  = HOST;
   int m_cnt   = 0;
   bit m_used  = 1'b0;
   bit m_locked [M];
   bit seen_edge = 1'b0;

   // bus agent state
   int want [M];
   bit broken [M];
   bit pause [M];
   bit req_drv [M];
   int tph = 0;

   always #10 clk = ~clk;

   pci_central_arbiter #(.N_EXT(N_EXT), .WINDOW(WIN)) u0 (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .host_req(host_req),
      .frame_n(frame_n), .irdy_n(irdy_n), .lock_dis(lock_dis),
      .park_mode(park_mode), .gnt_n(gnt_n), .host_gnt(host_gnt)
   );

   assign g_obs = {host_gnt, ~gnt_n};

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic count_grant(int idx, int n, output int c);
      c = 0;
      repeat (n) begin
         @(negedge clk);
         #1;
         if (g_obs[idx]) c++;
      end
   endtask

   // behavioural cycle model of the arbitration rules
   always @(posedge clk) begin : model
      bit rq [M];
      bit el [M];
      bit nl [M];
      int found, tgt, k, idx;
      bit idle, pok, oel, counting, expire, keep;
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, 20000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
      seen_edge = 1'b1;
      if (!rst_n) begin
         m_owner = -1; m_last = HOST; m_cnt = 0; m_used = 0;
         for (int i = 0; i < M; i++) m_locked[i] = 0;
      end else begin
         for (int i = 0; i < M; i++) begin
            rq[i] = (i == HOST) ? host_req : !req_n[i];
            el[i] = rq[i] && !m_locked[i];
         end
         idle  = frame_n && irdy_n;
         found = -1;
         for (k = 1; k <= M; k++) begin
            idx = (m_last + k) % M;
            if (found < 0 && el[idx]) found = idx;
         end
         tgt = (park_mode == 2'b00) ? m_last : (park_mode == 2'b01) ? 0 : HOST;
         pok = !m_locked[tgt];
         oel = (m_owner >= 0) && el[m_owner];
         counting = (m_owner >= 0) && idle && !m_used && oel;
         expire = !lock_dis && counting && (m_cnt == WIN - 1);
         for (int i = 0; i < M; i++) begin
            if (expire && i == m_owner) nl[i] = 1;
            else if (!rq[i]) nl[i] = 0;
            else nl[i] = m_locked[i];
         end
         if (!counting || expire) m_cnt = 0;
         else if (m_cnt < WIN - 1) m_cnt++;
         if (m_owner < 0) begin
            m_used = 0;
            if (idle) begin
               if (found >= 0) begin m_owner = found; m_last = found; end
               else if (pok) begin m_owner = tgt; m_last = tgt; end
            end
         end else if (!idle) begin
            m_used = 1;
         end else if (expire) begin
            m_owner = -1;
         end else if (m_used || !oel) begin
            keep = (found >= 0) ? (found == m_owner) : (pok && tgt == m_owner);
            if (keep) m_used = 0;
            else m_owner = -1;
         end
         for (int i = 0; i < M; i++) m_locked[i] = nl[i];
      end
   end

   // compare against the model, then let the agents react
   always @(negedge clk) begin : agent
      logic [M-1:0] exp_g;
      int st;
      if (seen_edge) begin
         exp_g = '0;
         if (m_owner >= 0) exp_g[m_owner] = 1'b1;
         checks++;
         if (g_obs !== exp_g) begin
            errors++;
            $display("FAIL %s cycle %0d: grants actual %b expected %b", cur_tag, cyc, g_obs, exp_g);
         end
      end
      if (tph == 0) begin
         st = -1;
         for (int i = 0; i < M; i++)
            if (g_obs[i] && req_drv[i] && !broken[i]) st = i;
         if (st >= 0) begin
            frame_n = 1'b0;
            irdy_n  = 1'b0;
            tph     = 1;
            if (want[st] > 0) want[st]--;
         end
      end else begin
         tph++;
         if (tph == 3) frame_n = 1'b1;
         if (tph == 4) begin irdy_n = 1'b1; tph = 0; end
      end
      for (int i = 0; i < M; i++) req_drv[i] = (want[i] > 0) && !pause[i];
      for (int i = 0; i < N_EXT; i++) req_n[i] = !req_drv[i];
      host_req = req_drv[HOST];
   end

   initial begin : scenario
      int c;
      for (int i = 0; i < M; i++) begin
         want[i] = 0; broken[i] = 0; pause[i] = 0; req_drv[i] = 0; m_locked[i] = 0;
      end
      tick(3);
      check(g_obs == '0, "R10", "grants in reset", int'(g_obs), 0);
      rst_n = 1'b1;
      tick(3);
      cur_tag = "R9";
      check(host_gnt == 1'b1, "R9", "host parked (code 10)", int'(host_gnt), 1);
      park_mode = 2'b11;
      tick(5);
      check(host_gnt == 1'b1, "R9", "host parked (code 11)", int'(host_gnt), 1);
      cur_tag = "R8";
      park_mode = 2'b01;
      tick(4);
      check(gnt_n[0] == 1'b0, "R8", "master 0 parked", int'(!gnt_n[0]), 1);
      // R2 / R6: contention among several masters
      cur_tag = "R2";
      park_mode = 2'b00;
      want[1] = 2; want[2] = 1; want[3] = 1; want[HOST] = 1;
      tick(60);
      check(want[1] + want[2] + want[3] + want[HOST] == 0, "R2", "requests left", want[1] + want[2] + want[3] + want[HOST], 0);
      cur_tag = "R7";
      want[3] = 1;
      tick(15);
      check(gnt_n[3] == 1'b0, "R7", "parked on last master 3", int'(!gnt_n[3]), 1);
      // R3: stalled master
      cur_tag = "R3";
      broken[2] = 1; want[2] = 1;
      count_grant(2, 40, c);
      check(c == WIN, "R3", "grant cycles of stalled master", c, WIN);
      cur_tag = "R10";
      check(g_obs == '0, "R10", "no park on excluded master", int'(g_obs), 0);
      cur_tag = "R4";
      want[1] = 1;
      tick(20);
      check(want[1] == 0, "R4", "other master served during exclusion", want[1], 0);
      count_grant(2, 20, c);
      check(c == 0, "R4", "excluded master grant cycles", c, 0);
      pause[2] = 1;
      tick(1);
      pause[2] = 0; broken[2] = 0;
      tick(30);
      check(want[2] == 0, "R4", "served after releasing request", want[2], 0);
      // R5: exclusion disabled
      cur_tag = "R5";
      lock_dis = 1'b1; park_mode = 2'b10;
      broken[3] = 1; want[3] = 1;
      tick(60);
      check(gnt_n[3] == 1'b0, "R5", "stalled master keeps grant", int'(!gnt_n[3]), 1);
      want[HOST] = 1;
      tick(20);
      check(host_gnt == 1'b0, "R5", "host waits behind holder", int'(host_gnt), 0);
      broken[3] = 0;
      tick(20);
      check(want[HOST] == 0, "R5", "host served after holder ran", want[HOST], 0);
      lock_dis = 1'b0;
      // R6: repeated cycles by a sole requester
      cur_tag = "R6";
      want[1] = 3;
      tick(40);
      check(want[1] == 0, "R6", "sole requester cycles left", want[1], 0);
      // R3 / R1: expiry and fresh request on the same edge
      cur_tag = "R3";
      park_mode = 2'b10;
      tick(5);
      broken[1] = 1; want[1] = 1;
      while (!g_obs[1]) tick(1);
      tick(14);
      want[0] = 1;
      tick(2);
      check(g_obs == '0, "R1", "empty cycle after expiry", int'(g_obs), 0);
      tick(1);
      check(gnt_n[0] == 1'b0, "R3", "newcomer granted after expiry", int'(!gnt_n[0]), 1);
      tick(10);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule